// File: doc/BRIEF.md
# Raster Line Timer with Tile Animation Counter

This block keeps the vertical timing of a video frame. A 9-bit line register steps once per line-end strobe through the values 0x0F8 to 0x1FF and then wraps. From that value it derives the current video phase: sync, top border, active picture or bottom border. Each wrap marks a new frame. The wrap raises a vertical blank interrupt and clocks a 3-bit tile animation counter. That counter advances once every programmable number of frames.

A 32-bit pixel countdown is clocked by the pixel clock enable. When it reaches zero it can raise a raster-position interrupt. A three-bit field selects when the countdown is reloaded. A third interrupt source comes in on a pin. Software sees a 16-bit status word. It writes a 16-bit control word, two 16-bit halves of the pixel position, and an acknowledge byte that clears pending interrupts bit by bit.

Top module: `raster_line_timer`

## Requirements
- R1: The line register resets to 0x0F8. On each cycle with `line_end` high it steps by one, and from 0x1FF it goes back to 0x0F8. Without `line_end` it holds.
- R2: `video_phase` is 0 for lines 0x0F8-0x0FF (sync), 1 for 0x100-0x10F (top border), 2 for 0x110-0x1EF (active) and 3 for 0x1F0-0x1FF (bottom border).
- R3: `status_word` carries the line in bits 15:7, zeros in bits 6:4, the `frame_50hz` input in bit 3 and the animation counter in bits 2:0.
- R4: Write select codes are: 0 = control, 1 = position high half, 2 = position low half, 3 = acknowledge. Control bits 15:8 hold a frame period P. The animation counter advances by one, modulo 8, on every (P+1)-th frame wrap.
- R5: While control bit 3 is set, the animation counter and its frame prescaler hold their values.
- R6: A wrap from 0x1FF to 0x0F8 sets pending bit 2 (vertical blank).
- R7: The countdown steps down by one on each `pix_ce` while it is nonzero. The step from 1 to 0 sets pending bit 1 only if control bit 4 is set.
- R8: The reload mode is set by three control bits. With bit 5 set, a low-half write loads the countdown with {high half, written data}. With bit 6 set, every frame wrap reloads it from the stored position. With bit 7 set, reaching zero reloads it from the stored position. A low-half load beats a frame reload, and both beat counting.
- R9: A cycle with `ext_irq_evt` high sets pending bit 0.
- R10: An acknowledge write clears each pending bit whose data bit (2, 1 or 0) is one. It wins over an event for the same bit in the same cycle.
- R11: `irq` is high exactly when any pending bit is set.
- R12: After reset: line 0x0F8, animation counter 0, control and position 0, nothing pending, `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel clock enable |
| line_end | input | 1 | One-cycle strobe at the end of each line |
| frame_50hz | input | 1 | Frame rate strap, 1 = 50 Hz |
| ext_irq_evt | input | 1 | Event of the third interrupt source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 position high, 2 position low, 3 acknowledge) |
| wr_data | input | 16 | Write data |
| status_word | output | 16 | Line, rate bit and animation counter |
| video_phase | output | 2 | Current vertical phase |
| irq_pending | output | 3 | Pending bits: 2 vertical blank, 1 raster, 0 external |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the line register steps, holds and wraps as required and never leaves its range. They also check that the animation counter only ever advances by one and is frozen while disabled, that a wrap and an external event always set their pending bits, and that an acknowledge always clears its bits. Some behaviour only the bench scenarios can show: the exact (P+1)-frame cadence of the animation counter, the point at which the pixel countdown expires under each reload mode, and the gating by the raster enable. For these the bench runs a behavioural model next to the design and compares with it on every cycle.

// File: rtl/rlt_pkg.sv
package rlt_pkg;
    localparam int LINE_W   = 9;
    localparam int ANIM_W   = 3;
    localparam int PERIOD_W = 8;
    localparam int HALF_W   = 16;
    localparam int POS_W    = 2 * HALF_W;
    localparam int IRQ_N    = 3;

    localparam logic [LINE_W-1:0] LINE_FIRST   = 9'h0F8;
    localparam logic [LINE_W-1:0] LINE_LAST    = 9'h1FF;
    localparam logic [LINE_W-1:0] TOP_FIRST    = 9'h100;
    localparam logic [LINE_W-1:0] ACTIVE_FIRST = 9'h110;
    localparam logic [LINE_W-1:0] BOTTOM_FIRST = 9'h1F0;

    localparam int IRQ_VBL    = 2;
    localparam int IRQ_RASTER = 1;
    localparam int IRQ_EXT    = 0;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_TOP    = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_BOTTOM = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_POS_HI = 2'd1,
        SEL_POS_LO = 2'd2,
        SEL_ACK    = 2'd3
    } sel_e;

    // control word bits 15:3
    typedef struct packed {
        logic [PERIOD_W-1:0] period;          // 15:8
        logic                reload_on_zero;  // 7
        logic                reload_on_frame; // 6
        logic                load_on_write;   // 5
        logic                raster_en;       // 4
        logic                anim_off;        // 3
    } ctrl_t;

    function automatic phase_e phase_of(input logic [LINE_W-1:0] l);
        if (l < TOP_FIRST)         return PH_SYNC;
        else if (l < ACTIVE_FIRST) return PH_TOP;
        else if (l < BOTTOM_FIRST) return PH_ACTIVE;
        else                       return PH_BOTTOM;
    endfunction
endpackage

// File: rtl/rlt_line_counter.sv
module rlt_line_counter
    import rlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    output logic [LINE_W-1:0] line,
    output logic              frame_wrap
);
    assign frame_wrap = line_end && (line == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            line <= LINE_FIRST;
        else if (line_end)
            line <= frame_wrap ? LINE_FIRST : line + 1'b1;
    end
endmodule

// File: rtl/rlt_anim_counter.sv
module rlt_anim_counter #(
    parameter int PER_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             hold,
    input  logic [PER_W-1:0] period,
    output logic [CNT_W-1:0] anim
);
    logic [PER_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            anim  <= '0;
        end else if (frame_tick && !hold) begin
            if (pre_q == period) begin
                pre_q <= '0;
                anim  <= anim + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rlt_raster_countdown.sv
module rlt_raster_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_ce,
    input  logic         load_now,
    input  logic [W-1:0] load_val,
    input  logic         frame_reload,
    input  logic         zero_reload,
    input  logic [W-1:0] reload_val,
    input  logic         enable,
    output logic         hit
);
    logic [W-1:0] cnt_q;
    logic         expire;

    assign expire = pix_ce && (cnt_q == W'(1)) && !load_now && !frame_reload;
    assign hit    = expire && enable;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_now)
            cnt_q <= load_val;
        else if (frame_reload)
            cnt_q <= reload_val;
        else if (expire)
            cnt_q <= zero_reload ? reload_val : '0;
        else if (pix_ce && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/raster_line_timer.sv
module raster_line_timer
    import rlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_ce,
    input  logic              line_end,
    input  logic              frame_50hz,
    input  logic              ext_irq_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0] status_word,
    output logic [1:0]        video_phase,
    output logic [IRQ_N-1:0]  irq_pending,
    output logic              irq
);
    ctrl_t              ctrl_q;
    logic [POS_W-1:0]   pos_q;
    logic [LINE_W-1:0]  line_q;
    logic [ANIM_W-1:0]  anim_q;
    logic [IRQ_N-1:0]   pend_q;
    logic               frame_wrap;
    logic               raster_hit;
    logic               load_now;
    logic [IRQ_N-1:0]   events;
    logic [IRQ_N-1:0]   ack_mask;
    sel_e               sel;

    assign sel = sel_e'(wr_sel);

    rlt_line_counter u_line (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .line       (line_q),
        .frame_wrap (frame_wrap)
    );

    rlt_anim_counter #(.PER_W(PERIOD_W), .CNT_W(ANIM_W)) u_anim (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_wrap),
        .hold       (ctrl_q.anim_off),
        .period     (ctrl_q.period),
        .anim       (anim_q)
    );

    assign load_now = wr_en && (sel == SEL_POS_LO) && ctrl_q.load_on_write;

    rlt_raster_countdown #(.W(POS_W)) u_cdown (
        .clk          (clk),
        .rst          (rst),
        .pix_ce       (pix_ce),
        .load_now     (load_now),
        .load_val     ({pos_q[POS_W-1:HALF_W], wr_data}),
        .frame_reload (frame_wrap && ctrl_q.reload_on_frame),
        .zero_reload  (ctrl_q.reload_on_zero),
        .reload_val   (pos_q),
        .enable       (ctrl_q.raster_en),
        .hit          (raster_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pos_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL:   ctrl_q                 <= ctrl_t'(wr_data[HALF_W-1:3]);
                SEL_POS_HI: pos_q[POS_W-1:HALF_W]  <= wr_data;
                SEL_POS_LO: pos_q[HALF_W-1:0]      <= wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        events             = '0;
        events[IRQ_VBL]    = frame_wrap;
        events[IRQ_RASTER] = raster_hit;
        events[IRQ_EXT]    = ext_irq_evt;
        ack_mask = (wr_en && sel == SEL_ACK) ? wr_data[IRQ_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | events) & ~ack_mask;
    end

    assign status_word = {line_q, 3'b000, frame_50hz, anim_q};
    assign video_phase = phase_of(line_q);
    assign irq_pending = pend_q;
    assign irq         = |pend_q;
endmodule

// File: rtl/rlt_checker.sv
module rlt_checker
    import rlt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_end,
    input logic [LINE_W-1:0] line,
    input logic [ANIM_W-1:0] anim,
    input logic              anim_off,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [HALF_W-1:0] wr_data,
    input logic              ext_evt,
    input logic [IRQ_N-1:0]  pend
);
    logic ack_wr;
    assign ack_wr = wr_en && (wr_sel == 2'd3);

    p_line_range_r1: assert property (@(posedge clk) disable iff (rst)
        line >= LINE_FIRST);
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (line_end && line == LINE_LAST) |=> line == LINE_FIRST);
    p_line_step_r1: assert property (@(posedge clk) disable iff (rst)
        (line_end && line != LINE_LAST) |=> line == $past(line) + 1'b1);
    p_line_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(line));
    p_anim_step_r4: assert property (@(posedge clk) disable iff (rst)
        (anim != $past(anim)) |-> (anim == $past(anim) + 1'b1));
    p_anim_hold_r5: assert property (@(posedge clk) disable iff (rst)
        anim_off |=> $stable(anim));
    p_vbl_pend_r6: assert property (@(posedge clk) disable iff (rst)
        (line_end && line == LINE_LAST && !(ack_wr && wr_data[IRQ_VBL])) |=> pend[IRQ_VBL]);
    p_ext_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (ext_evt && !(ack_wr && wr_data[IRQ_EXT])) |=> pend[IRQ_EXT]);

    for (genvar k = 0; k < IRQ_N; k++) begin : g_ack
        p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (ack_wr && wr_data[k]) |=> !pend[k]);
    end
endmodule

bind raster_line_timer rlt_checker u_rlt_checker (
    .clk      (clk),
    .rst      (rst),
    .line_end (line_end),
    .line     (line_q),
    .anim     (anim_q),
    .anim_off (ctrl_q.anim_off),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ext_evt  (ext_irq_evt),
    .pend     (pend_q)
);

// File: tb/test_raster_line_timer.sv
`timescale 1ns/1ps
module test_raster_line_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_ce = 1'b0, line_end = 1'b0, frame_50hz = 1'b0, ext_irq_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] status_word;
    logic [1:0]  video_phase;
    logic [2:0]  irq_pending;
    logic        irq;

    int checks = 0, failures = 0, cyc = 0, gcnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    raster_line_timer i_raster_line_timer (
        .clk(clk), .rst(rst), .pix_ce(pix_ce), .line_end(line_end),
        .frame_50hz(frame_50hz), .ext_irq_evt(ext_irq_evt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_word(status_word), .video_phase(video_phase),
        .irq_pending(irq_pending), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_line, m_anim, m_pre;
    logic [15:0] m_ctrl;
    logic [31:0] m_pos, m_cnt;
    logic [2:0]  m_pend;

    always @(posedge clk) begin
        bit wrap, rev;
        logic [2:0] ack;
        cyc++;
        if (rst) begin
            m_line = 'h0F8; m_anim = 0; m_pre = 0;
            m_ctrl = 0; m_pos = 0; m_cnt = 0; m_pend = 0;
        end else begin
            wrap = line_end && (m_line == 'h1FF);
            if (line_end) m_line = wrap ? 'h0F8 : m_line + 1;
            if (wrap && !m_ctrl[3]) begin
                if (m_pre == int'(m_ctrl[15:8])) begin m_pre = 0; m_anim = (m_anim + 1) % 8; end
                else m_pre = m_pre + 1;
            end
            rev = 1'b0;
            if (wr_en && wr_sel == 2'd2 && m_ctrl[5]) m_cnt = {m_pos[31:16], wr_data};
            else if (wrap && m_ctrl[6]) m_cnt = m_pos;
            else if (pix_ce && m_cnt != 0) begin
                if (m_cnt == 1) begin rev = m_ctrl[4]; m_cnt = m_ctrl[7] ? m_pos : 32'd0; end
                else m_cnt = m_cnt - 1;
            end
            ack = (wr_en && wr_sel == 2'd3) ? wr_data[2:0] : 3'b000;
            m_pend = (m_pend | {wrap, rev, ext_irq_evt}) & ~ack;
            if (wr_en && wr_sel == 2'd0) m_ctrl = wr_data & 16'hFFF8;
            if (wr_en && wr_sel == 2'd1) m_pos[31:16] = wr_data;
            if (wr_en && wr_sel == 2'd2) m_pos[15:0] = wr_data;
        end
    end

    function automatic int exp_phase(input int l);
        if (l < 'h100) return 0;
        if (l < 'h110) return 1;
        if (l < 'h1F0) return 2;
        return 3;
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(status_word[15:7] == m_line[8:0], "R1 line", status_word[15:7], m_line);
            check(video_phase == exp_phase(m_line), "R2 phase", video_phase, exp_phase(m_line));
            check(status_word[6:3] == {3'b000, frame_50hz}, "R3 status bits 6:3", status_word[6:3], {3'b000, frame_50hz});
            check(status_word[2:0] == m_anim[2:0], "R4 anim", status_word[2:0], m_anim);
            check(irq_pending[2] == m_pend[2], "R6 vblank pending", irq_pending[2], m_pend[2]);
            check(irq_pending[1] == m_pend[1], "R7 raster pending", irq_pending[1], m_pend[1]);
            check(irq_pending[0] == m_pend[0], "R9 ext pending", irq_pending[0], m_pend[0]);
            check(irq == (|m_pend), "R11 irq", irq, |m_pend);
        end
    end

    // background line / pixel strobes
    always @(negedge clk) begin
        if (rst) gcnt = 0;
        else begin
            gcnt++;
            line_end = (gcnt % 4 == 0);
            pix_ce   = (gcnt % 3 != 0);
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [2:0] held;
        wait_cycles(5);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(status_word == 16'h7C00, "R12 reset status", status_word, 16'h7C00);
        check(irq_pending == 3'b000 && irq == 1'b0, "R12 reset irq", {irq, irq_pending}, 0);
        check(video_phase == 2'd0, "R12 reset phase", video_phase, 0);

        // default period 0: anim every frame, vblank each wrap
        wait_cycles(2200);
        reg_write(2'd3, 16'h0004);
        check(irq_pending[2] == 1'b0, "R10 vblank ack", irq_pending[2], 0);

        // period 2
        reg_write(2'd0, 16'h0200);
        wait_cycles(4000);

        // R5 hold while disabled
        reg_write(2'd0, 16'h0008);
        held = status_word[2:0];
        wait_cycles(2300);
        check(status_word[2:0] == held, "R5 anim held", status_word[2:0], held);
        reg_write(2'd0, 16'h0000);

        // R7 countdown, enabled, load on low write
        reg_write(2'd0, 16'h0030);
        reg_write(2'd1, 16'h0000);
        reg_write(2'd2, 16'd100);
        wait_cycles(300);
        check(irq_pending[1] == 1'b1, "R7 raster hit", irq_pending[1], 1);
        reg_write(2'd3, 16'h0002);
        check(irq_pending[1] == 1'b0, "R10 raster ack", irq_pending[1], 0);

        // R8 periodic reload on zero
        reg_write(2'd0, 16'h00B0);
        reg_write(2'd2, 16'd40);
        wait_cycles(200);
        reg_write(2'd3, 16'h0002);
        wait_cycles(200);
        check(irq_pending[1] == 1'b1, "R8 periodic reload", irq_pending[1], 1);

        // R7 raster disabled: no pending
        reg_write(2'd0, 16'h0020);
        reg_write(2'd3, 16'h0002);
        reg_write(2'd2, 16'd30);
        wait_cycles(200);
        check(irq_pending[1] == 1'b0, "R7 raster disabled", irq_pending[1], 0);

        // R8 reload at frame wrap
        reg_write(2'd0, 16'h0050);
        reg_write(2'd2, 16'd16);
        reg_write(2'd3, 16'h0002);
        wait_cycles(1200);
        check(irq_pending[1] == 1'b1, "R8 frame reload", irq_pending[1], 1);
        reg_write(2'd3, 16'h0007);

        // R9 / R11 external event
        @(negedge clk); ext_irq_evt = 1'b1;
        @(negedge clk); ext_irq_evt = 1'b0;
        check(irq_pending[0] == 1'b1 && irq == 1'b1, "R11 irq from ext", {irq, irq_pending[0]}, 2'b11);
        reg_write(2'd3, 16'h0001);
        // R10 ack beats same-cycle event
        @(negedge clk);
        ext_irq_evt = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0001;
        @(negedge clk);
        ext_irq_evt = 1'b0; wr_en = 1'b0; wr_data = 16'h0;
        check(irq_pending[0] == 1'b0, "R10 ack priority", irq_pending[0], 0);

        // R3 rate bit
        @(negedge clk); frame_50hz = 1'b1;
        wait_cycles(2);
        check(status_word[3] == 1'b1, "R3 rate bit", status_word[3], 1);

        // R12 reset mid-run
        rst = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check(status_word == 16'h7C08 && irq_pending == 3'b000, "R12 second reset",
              {status_word, irq_pending}, {16'h7C08, 3'b000});
        wait_cycles(50);
        finish_run();
    end
endmodule